// File: doc/BRIEF.md
# Variable-Ways Cache Placement Controller

This block is the tag store and placement logic of a first-level set-associative cache whose sets can grow past their nominal associativity. When a set runs out of room it may borrow the empty ways of exactly one other set, its partner. A set picks its partner the first time it overflows: it takes the set with the most empty ways among those not already lending to another set. Each stored line carries an ownership bit. The bit tells whether the line belongs to the set it sits in or was placed there for the borrowing set.

Power is tracked per way. After reset every way is off. A way switches on the first time a line is written into it and stays on from then on. A powered-off way never produces a tag match. The block reports how many ways are currently powered, which the surrounding power accounting uses.

Requests arrive one at a time on a valid/ready channel carrying a line address. A small multicycle state machine probes the mapped set, then the partner set if one is assigned, and then either fills, evicts or walks all sets one per cycle to pick a partner. It ends every request with a one-cycle response. The response gives the hit flag, a flag for a hit found in the partner, and the set and way that were read or written. Data storage is handled elsewhere.

Top module: `vway_cache_ctrl`

## Requirements
- R1: The set index is the line address modulo the number of sets (its low bits), and the tag is the address divided by the number of sets. A hit or a fill in the mapped set reports that set index.
- R2: After reset no way is powered: `ways_on` is 0, `req_ready` is 1 and `resp_valid` is 0. A stored line never sits in an unpowered way.
- R3: A miss whose mapped set has an empty way fills the lowest-numbered empty way of that set, marks it as owned by that set and powers it, raising `ways_on` by one. Repeating the address then hits that set and way with the partner flag 0.
- R4: When the mapped set misses and a partner is assigned, the partner is probed as well. A hit there returns `resp_hit`=1, `resp_part`=1 and the partner's set and way. The partner flag is never 1 without a hit.
- R5: A miss in a full set with no partner scans every set and claims as partner the one with the most empty ways. The scan skips the mapped set and any set already serving as a partner, and breaks ties by the lowest index. The line goes into the lowest empty way of the claimed set, and the response reports that set.
- R6: A miss in a full set whose partner has an empty way fills the partner's lowest empty way. A set keeps its partner for the rest of operation.
- R7: A line matches only when both its tag and its ownership agree. In the mapped set only lines owned by that set match, and in the partner only lines placed for the borrowing set match.
- R8: A miss with both the mapped set and its partner full replaces the least recently used way of the mapped set, clears that way's ownership bit, and reports the mapped set and the replaced way with hit 0. The replaced line then misses.
- R9: Every hit and every fill makes the accessed way the most recently used of its set. Hits therefore change which way a later replacement picks.
- R10: `ways_on` never decreases. It rises by exactly one only in a cycle where a miss response is presented, and a hit or a replacement leaves it unchanged.
- R11: `req_ready` is low from acceptance until the response. `resp_valid` lasts one cycle. The latency from acceptance to response is at most the number of sets plus four cycles.
- R12: If a partner scan finds no eligible set with an empty way, no partner is recorded and the least recently used way of the mapped set is replaced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_addr | input | ADDRW | Line address of the request |
| req_ready | output | 1 | Controller idle and able to accept |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_hit | output | 1 | Line was found |
| resp_part | output | 1 | Hit came from the partner set |
| resp_set | output | log2(NSETS) | Set that was read or written |
| resp_way | output | log2(NWAYS) | Way that was read or written |
| ways_on | output | log2(NSETS*NWAYS+1) | Number of powered ways |

## Verification
A corrupted valid, tag or ownership bit shows up at the ports on the next request to the affected address. That request returns a wrong hit flag, a wrong partner flag or a wrong way, and a wrong power count can follow from it. A wrong partner register or a wrong LRU rank stays hidden until the mapped set overflows or a replacement occurs; it then appears as a wrong set or way in that response. For this reason, a long address stream that fills many sets and forces claims and replacements is compared response by response against an independent model of the placement rules.

// File: rtl/vway_pkg.sv
// Shared types for the variable-ways placement controller.
// Assumes nothing beyond a synthesizable enum encoding.
package vway_pkg;

    // Controller sequencing states.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HOME,
        ST_PART,
        ST_SCAN,
        ST_CLAIM
    } vway_state_t;

endpackage

// File: rtl/vway_set_probe.sv
// Combinational view of one set: tag match with ownership, first empty way
// and number of empty ways. Assumes an unpowered way never matches.
module vway_set_probe #(
    parameter int NWAYS = 4,
    parameter int TAGW  = 8,
    parameter int WAYW  = $clog2(NWAYS),
    parameter int ECW   = $clog2(NWAYS + 1)
) (
    input  logic [NWAYS-1:0]           vld,
    input  logic [NWAYS-1:0]           en,
    input  logic [NWAYS-1:0]           own,
    input  logic [NWAYS-1:0][TAGW-1:0] tags,
    input  logic [TAGW-1:0]            look_tag,
    input  logic                       want_own,
    output logic                       hit,
    output logic [WAYW-1:0]            hit_way,
    output logic                       has_empty,
    output logic [WAYW-1:0]            empty_way,
    output logic [ECW-1:0]             empty_cnt
);

    // Scan ways from the top so the lowest index wins.
    always_comb begin
        hit       = 1'b0;
        hit_way   = '0;
        has_empty = 1'b0;
        empty_way = '0;
        empty_cnt = '0;
        for (int w = NWAYS - 1; w >= 0; w--) begin
            if (vld[w] && en[w] && (own[w] == want_own) && (tags[w] == look_tag)) begin
                hit     = 1'b1;
                hit_way = WAYW'(w);
            end
            if (!vld[w]) begin
                has_empty = 1'b1;
                empty_way = WAYW'(w);
            end
            empty_cnt = empty_cnt + ECW'(!vld[w]);
        end
    end

endmodule

// File: rtl/vway_lru_set.sv
// Recency ranks for one set (0 = most recent). A touch promotes a way to
// rank 0 and ages the ways that were more recent. Assumes ranks form a
// permutation, which reset establishes.
module vway_lru_set #(
    parameter int NWAYS = 4,
    parameter int WAYW  = $clog2(NWAYS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            touch,
    input  logic [WAYW-1:0] touch_way,
    output logic [WAYW-1:0] victim
);

    logic [WAYW-1:0] rank [NWAYS];

    // Update ranks on a touch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int w = 0; w < NWAYS; w++) rank[w] <= WAYW'(w);
        end else if (touch) begin
            for (int w = 0; w < NWAYS; w++) begin
                if (WAYW'(w) == touch_way)
                    rank[w] <= '0;
                else if (rank[w] < rank[touch_way])
                    rank[w] <= rank[w] + 1'b1;
            end
        end
    end

    // Victim is the way holding the oldest rank.
    always_comb begin
        victim = '0;
        for (int w = 0; w < NWAYS; w++)
            if (rank[w] == WAYW'(NWAYS - 1)) victim = WAYW'(w);
    end

endmodule

// File: rtl/vway_popcount.sv
// Counts set bits of a flat vector; used for the powered-way total.
module vway_popcount #(
    parameter int N  = 64,
    parameter int CW = $clog2(N + 1)
) (
    input  logic [N-1:0]  bits,
    output logic [CW-1:0] count
);

    // Sum all bits.
    always_comb begin
        count = '0;
        for (int i = 0; i < N; i++) count = count + CW'(bits[i]);
    end

endmodule

// File: rtl/vway_cache_ctrl.sv
// Variable-ways tag store and placement controller. One request at a time:
// probe mapped set, probe partner, fill / replace, or scan all sets (one per
// cycle) to claim a partner. Ways power on at first fill and stay on.
// Assumes NSETS and NWAYS are powers of two and ADDRW > log2(NSETS).
module vway_cache_ctrl #(
    parameter int NSETS = 16,
    parameter int NWAYS = 4,
    parameter int ADDRW = 12,
    parameter int SETW  = $clog2(NSETS),
    parameter int WAYW  = $clog2(NWAYS),
    parameter int CNTW  = $clog2(NSETS * NWAYS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [ADDRW-1:0] req_addr,
    output logic             req_ready,
    output logic             resp_valid,
    output logic             resp_hit,
    output logic             resp_part,
    output logic [SETW-1:0]  resp_set,
    output logic [WAYW-1:0]  resp_way,
    output logic [CNTW-1:0]  ways_on
);
    import vway_pkg::*;

    localparam int TAGW  = ADDRW - SETW;
    localparam int ECW   = $clog2(NWAYS + 1);
    localparam int TOTAL = NSETS * NWAYS;

    // Per-way and per-set state.
    logic [NWAYS-1:0]           vld   [NSETS];
    logic [NWAYS-1:0]           en    [NSETS];
    logic [NWAYS-1:0]           own   [NSETS];
    logic [NWAYS-1:0][TAGW-1:0] tagm  [NSETS];
    logic [SETW-1:0]            ptr   [NSETS];
    logic [NSETS-1:0]           ptr_ok;
    logic [NSETS-1:0]           serving;

    // Request context.
    vway_state_t     state, nxt;
    logic [SETW-1:0] a_set, scan_idx, best_set, s_idx, p_set;
    logic [TAGW-1:0] a_tag;
    logic [ECW-1:0]  best_cnt;

    // Probe results.
    logic            h_hit, h_empty, p_hit, p_empty, s_hit, s_empty;
    logic [WAYW-1:0] h_hway, h_eway, p_hway, p_eway, s_hway, s_eway;
    logic [ECW-1:0]  h_cnt, p_cnt, s_cnt;
    logic            s_elig;

    // Decisions.
    logic            fill_go, fill_o, claim_go, touch_go, resp_go, r_hit, r_part;
    logic [SETW-1:0] fill_s, touch_s;
    logic [WAYW-1:0] fill_w, touch_w;

    logic [WAYW-1:0]  victim [NSETS];
    logic [TOTAL-1:0] en_flat, vld_flat;

    assign p_set  = ptr[a_set];
    assign s_idx  = (state == ST_CLAIM) ? best_set : scan_idx;
    assign s_elig = !serving[scan_idx] && (scan_idx != a_set);

    vway_set_probe #(.NWAYS(NWAYS), .TAGW(TAGW), .WAYW(WAYW), .ECW(ECW)) u_home (
        .vld(vld[a_set]), .en(en[a_set]), .own(own[a_set]), .tags(tagm[a_set]),
        .look_tag(a_tag), .want_own(1'b0), .hit(h_hit), .hit_way(h_hway),
        .has_empty(h_empty), .empty_way(h_eway), .empty_cnt(h_cnt));

    vway_set_probe #(.NWAYS(NWAYS), .TAGW(TAGW), .WAYW(WAYW), .ECW(ECW)) u_part (
        .vld(vld[p_set]), .en(en[p_set]), .own(own[p_set]), .tags(tagm[p_set]),
        .look_tag(a_tag), .want_own(1'b1), .hit(p_hit), .hit_way(p_hway),
        .has_empty(p_empty), .empty_way(p_eway), .empty_cnt(p_cnt));

    vway_set_probe #(.NWAYS(NWAYS), .TAGW(TAGW), .WAYW(WAYW), .ECW(ECW)) u_scan (
        .vld(vld[s_idx]), .en(en[s_idx]), .own(own[s_idx]), .tags(tagm[s_idx]),
        .look_tag(a_tag), .want_own(1'b1), .hit(s_hit), .hit_way(s_hway),
        .has_empty(s_empty), .empty_way(s_eway), .empty_cnt(s_cnt));

    // One recency tracker per set, plus flattened power and valid vectors.
    for (genvar s = 0; s < NSETS; s++) begin : g_set
        vway_lru_set #(.NWAYS(NWAYS), .WAYW(WAYW)) u_lru (
            .clk(clk), .rst_n(rst_n),
            .touch(touch_go && (touch_s == SETW'(s))),
            .touch_way(touch_w), .victim(victim[s]));
        assign en_flat[s*NWAYS +: NWAYS]  = en[s];
        assign vld_flat[s*NWAYS +: NWAYS] = vld[s];
    end

    vway_popcount #(.N(TOTAL), .CW(CNTW)) u_cnt (.bits(en_flat), .count(ways_on));

    assign req_ready = (state == ST_IDLE);

    // Next-state and placement decision for the current step.
    always_comb begin
        nxt      = state;
        fill_go  = 1'b0;
        fill_s   = a_set;
        fill_w   = '0;
        fill_o   = 1'b0;
        claim_go = 1'b0;
        touch_go = 1'b0;
        touch_s  = a_set;
        touch_w  = '0;
        resp_go  = 1'b0;
        r_hit    = 1'b0;
        r_part   = 1'b0;
        case (state)
            ST_IDLE: if (req_valid) nxt = ST_HOME;
            ST_HOME: begin
                if (h_hit) begin
                    touch_go = 1'b1; touch_w = h_hway; r_hit = 1'b1; resp_go = 1'b1;
                    nxt = ST_IDLE;
                end else if (ptr_ok[a_set]) begin
                    nxt = ST_PART;
                end else if (h_empty) begin
                    fill_go = 1'b1; fill_w = h_eway; nxt = ST_IDLE;
                end else begin
                    nxt = ST_SCAN;
                end
            end
            ST_PART: begin
                nxt = ST_IDLE;
                if (p_hit) begin
                    touch_go = 1'b1; touch_s = p_set; touch_w = p_hway;
                    r_hit = 1'b1; r_part = 1'b1; resp_go = 1'b1;
                end else if (h_empty) begin
                    fill_go = 1'b1; fill_w = h_eway;
                end else if (p_empty) begin
                    fill_go = 1'b1; fill_s = p_set; fill_w = p_eway; fill_o = 1'b1;
                end else begin
                    fill_go = 1'b1; fill_w = victim[a_set];
                end
            end
            ST_SCAN: if (scan_idx == SETW'(NSETS - 1)) nxt = ST_CLAIM;
            ST_CLAIM: begin
                nxt     = ST_IDLE;
                fill_go = 1'b1;
                if (best_cnt != '0) begin
                    claim_go = 1'b1; fill_s = best_set; fill_w = s_eway; fill_o = 1'b1;
                end else begin
                    fill_w = victim[a_set];
                end
            end
            default: nxt = ST_IDLE;
        endcase
        if (fill_go) begin
            touch_go = 1'b1; touch_s = fill_s; touch_w = fill_w; resp_go = 1'b1;
        end
    end

    // Sequencing, request capture and scan bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            a_set    <= '0;
            a_tag    <= '0;
            scan_idx <= '0;
            best_set <= '0;
            best_cnt <= '0;
        end else begin
            state <= nxt;
            if (state == ST_IDLE && req_valid) begin
                a_set <= req_addr[SETW-1:0];
                a_tag <= req_addr[ADDRW-1:SETW];
            end
            if (state == ST_HOME) begin
                scan_idx <= '0;
                best_set <= '0;
                best_cnt <= '0;
            end else if (state == ST_SCAN) begin
                scan_idx <= scan_idx + 1'b1;
                if (s_elig && (s_cnt > best_cnt)) begin
                    best_set <= scan_idx;
                    best_cnt <= s_cnt;
                end
            end
        end
    end

    // Tag store, power bits and partner registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < NSETS; s++) begin
                vld[s]  <= '0;
                en[s]   <= '0;
                own[s]  <= '0;
                tagm[s] <= '0;
                ptr[s]  <= '0;
            end
            ptr_ok  <= '0;
            serving <= '0;
        end else begin
            if (fill_go) begin
                vld[fill_s][fill_w]  <= 1'b1;
                en[fill_s][fill_w]   <= 1'b1;
                own[fill_s][fill_w]  <= fill_o;
                tagm[fill_s][fill_w] <= a_tag;
            end
            if (claim_go) begin
                ptr[a_set]        <= best_set;
                ptr_ok[a_set]     <= 1'b1;
                serving[best_set] <= 1'b1;
            end
        end
    end

    // Registered response strobe and fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_valid <= 1'b0;
            resp_hit   <= 1'b0;
            resp_part  <= 1'b0;
            resp_set   <= '0;
            resp_way   <= '0;
        end else begin
            resp_valid <= resp_go;
            if (resp_go) begin
                resp_hit  <= r_hit;
                resp_part <= r_part;
                resp_set  <= touch_s;
                resp_way  <= touch_w;
            end
        end
    end

endmodule

// File: rtl/vway_cache_chk.sv
// Temporal checks on the controller's ports and its valid/power vectors.
module vway_cache_chk #(
    parameter int CNTW  = 7,
    parameter int TOTAL = 64
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_ready,
    input logic             resp_valid,
    input logic             resp_hit,
    input logic             resp_part,
    input logic [CNTW-1:0]  ways_on,
    input logic [TOTAL-1:0] vld_flat,
    input logic [TOTAL-1:0] en_flat
);

    // R11
    resp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> !resp_valid);

    // R11
    resp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> req_ready);

    // R4
    part_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_part) |-> resp_hit);

    // R10
    power_monotone_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ways_on >= $past(ways_on));

    // R10
    hit_keeps_power_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_hit) |-> (ways_on == $past(ways_on)));

    // R3
    power_on_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ways_on != $past(ways_on)) |-> (resp_valid && !resp_hit));

    // R2
    line_powered_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_flat & ~en_flat) == '0);

endmodule

bind vway_cache_ctrl vway_cache_chk #(.CNTW(CNTW), .TOTAL(NSETS * NWAYS)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .resp_valid(resp_valid),
    .resp_hit(resp_hit), .resp_part(resp_part), .ways_on(ways_on),
    .vld_flat(vld_flat), .en_flat(en_flat));

// File: tb/vway_cache_ctrl_tb.sv
// Directed scenarios plus a long address stream compared against a
// behavioural placement model written from the requirements.
module vway_cache_ctrl_tb;
    localparam int NS = 16;
    localparam int NW = 4;
    localparam int AW = 12;
    localparam int CLK_PERIOD = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic          req_ready, resp_valid, resp_hit, resp_part;
    logic [3:0]    resp_set;
    logic [1:0]    resp_way;
    logic [6:0]    ways_on;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Model state.
    int mv [NS][NW];
    int mt [NS][NW];
    int mo [NS][NW];
    int mr [NS][NW];
    int mp [NS];
    int mserv [NS];

    // Last response.
    int g_hit, g_part, g_set, g_way, g_cnt, g_lat, g_after;

    vway_cache_ctrl #(.NSETS(NS), .NWAYS(NW), .ADDRW(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_ready(req_ready), .resp_valid(resp_valid), .resp_hit(resp_hit),
        .resp_part(resp_part), .resp_set(resp_set), .resp_way(resp_way),
        .ways_on(ways_on));

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int s = 0; s < NS; s++) begin
            mp[s] = -1;
            mserv[s] = 0;
            for (int w = 0; w < NW; w++) begin
                mv[s][w] = 0; mt[s][w] = 0; mo[s][w] = 0; mr[s][w] = w;
            end
        end
    endtask

    task automatic m_touch(input int s, input int w);
        int r;
        r = mr[s][w];
        for (int k = 0; k < NW; k++)
            if (k == w) mr[s][k] = 0;
            else if (mr[s][k] < r) mr[s][k] = mr[s][k] + 1;
    endtask

    function automatic int m_first_empty(input int s);
        for (int w = 0; w < NW; w++) if (mv[s][w] == 0) return w;
        return -1;
    endfunction

    function automatic int m_empties(input int s);
        int n = 0;
        for (int w = 0; w < NW; w++) if (mv[s][w] == 0) n++;
        return n;
    endfunction

    task automatic m_place(input int s, input int w, input int t, input int o);
        mv[s][w] = 1; mt[s][w] = t; mo[s][w] = o;
        m_touch(s, w);
    endtask

    task automatic m_evict(input int h, input int t, output int w);
        w = 0;
        for (int k = 0; k < NW; k++) if (mr[h][k] == NW - 1) w = k;
        m_place(h, w, t, 0);
    endtask

    task automatic model_access(input int addr, output int hit, output int part,
                                output int set, output int way);
        int h, t, p, e, best, bc;
        h = addr % NS; t = addr / NS;
        hit = 0; part = 0; set = h; way = 0;
        for (int w = 0; w < NW; w++)
            if (mv[h][w] != 0 && mt[h][w] == t && mo[h][w] == 0 && hit == 0) begin
                hit = 1; way = w;
            end
        if (hit != 0) begin m_touch(h, way); return; end
        p = mp[h];
        if (p >= 0) begin
            for (int w = 0; w < NW; w++)
                if (mv[p][w] != 0 && mt[p][w] == t && mo[p][w] == 1 && hit == 0) begin
                    hit = 1; way = w;
                end
            if (hit != 0) begin part = 1; set = p; m_touch(p, way); return; end
        end
        e = m_first_empty(h);
        if (e >= 0) begin way = e; m_place(h, e, t, 0); return; end
        if (p >= 0) begin
            e = m_first_empty(p);
            if (e >= 0) begin set = p; way = e; m_place(p, e, t, 1); end
            else m_evict(h, t, way);
            return;
        end
        best = -1; bc = 0;
        for (int s = 0; s < NS; s++)
            if (s != h && mserv[s] == 0 && m_empties(s) > bc) begin
                best = s; bc = m_empties(s);
            end
        if (best >= 0) begin
            mp[h] = best; mserv[best] = 1;
            e = m_first_empty(best);
            set = best; way = e; m_place(best, e, t, 1);
        end else begin
            m_evict(h, t, way);
        end
    endtask

    function automatic int m_count();
        int n = 0;
        for (int s = 0; s < NS; s++)
            for (int w = 0; w < NW; w++) n += mv[s][w];
        return n;
    endfunction

    // Issue one request and capture the response; sampled at falling edges.
    task automatic do_req(input int addr);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_addr  = AW'(addr);
        @(negedge clk);
        req_valid = 1'b0;
        g_lat = 1;
        while (!resp_valid && g_lat < 100) begin
            @(negedge clk);
            g_lat++;
        end
        g_hit = resp_hit; g_part = resp_part; g_set = resp_set;
        g_way = resp_way; g_cnt = ways_on;
        @(negedge clk);
        g_after = resp_valid;
    endtask

    // Request, then compare every field against the model.
    task automatic req_cmp(input int addr);
        int eh, ep, es, ew;
        model_access(addr, eh, ep, es, ew);
        do_req(addr);
        chk(g_lat <= NS + 4, "R11 latency", g_lat, NS + 4);
        chk(g_after == 0, "R11 pulse width", g_after, 0);
        chk(g_hit == eh, "R4 R7 hit flag", g_hit, eh);
        chk(g_part == ep, "R4 partner flag", g_part, ep);
        chk(g_set == es, "R5 R6 R12 set", g_set, es);
        chk(g_way == ew, "R8 R9 way", g_way, ew);
        chk(g_cnt == m_count(), "R10 powered ways", g_cnt, m_count());
    endtask

    task automatic apply_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        model_reset();
    endtask

    initial begin : wdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        logic [15:0] lfsr;
        apply_reset();
        @(negedge clk);
        // R2 reset state
        chk(ways_on == 0, "R2 ways_on after reset", ways_on, 0);
        chk(req_ready == 1, "R2 ready after reset", req_ready, 1);
        chk(resp_valid == 0, "R2 no response after reset", resp_valid, 0);

        // R1 R3 first fill in set 5 and re-hit
        req_cmp('h05);
        chk(g_set == 5 && g_hit == 0, "R1 set index of fill", g_set, 5);
        chk(g_way == 0 && g_cnt == 1, "R3 lowest way powered", g_way, 0);
        req_cmp('h05);
        chk(g_hit == 1 && g_part == 0 && g_way == 0, "R3 re-hit home", g_hit, 1);
        req_cmp('h15); req_cmp('h25); req_cmp('h35);
        chk(g_way == 3 && g_cnt == 4, "R3 fourth fill", g_way, 3);

        // R5 overflow claims set 0 (all tied, lowest index)
        req_cmp('h45);
        chk(g_set == 0 && g_way == 0 && g_hit == 0, "R5 partner claim set", g_set, 0);
        req_cmp('h45);
        chk(g_hit == 1 && g_part == 1 && g_set == 0, "R4 partner hit", g_part, 1);

        // R7 same tag owned by partner set itself does not match
        req_cmp('h40);
        chk(g_hit == 0 && g_set == 0 && g_way == 1, "R7 ownership mismatch", g_hit, 0);

        // R6 further overflow into partner
        req_cmp('h55);
        chk(g_set == 0 && g_way == 2, "R6 partner fill", g_way, 2);
        req_cmp('h65);
        chk(g_set == 0 && g_way == 3 && g_cnt == 8, "R6 partner fill last", g_way, 3);

        // R8 both full: replace LRU of set 5 (way 0)
        req_cmp('h75);
        chk(g_set == 5 && g_way == 0 && g_hit == 0, "R8 replace LRU", g_way, 0);
        chk(g_cnt == 8, "R10 replacement keeps power", g_cnt, 8);
        req_cmp('h15);
        chk(g_hit == 1 && g_way == 1, "R9 hit promotes way 1", g_way, 1);
        req_cmp('h05);
        chk(g_hit == 0 && g_set == 5 && g_way == 2, "R8 R9 replaced line misses, victim way 2", g_way, 2);

        // R12 R5 R6 long streams: concentrated sets, then whole space
        lfsr = 16'hACE1;
        for (int i = 0; i < 6000; i++) begin
            int a;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            if (i < 2000) a = {lfsr[9:4], 2'b00, lfsr[1:0]};
            else a = {lfsr[10:4], lfsr[3:0]} % 512;
            req_cmp(a);
        end

        // R12 fallback on a fresh state: every set serving or full
        apply_reset();
        for (int s = 0; s < NS; s++)
            for (int t = 0; t < NW; t++) req_cmp(t * NS + s);
        req_cmp(NW * NS + 3);
        chk(g_set == 3 && g_hit == 0, "R12 fallback replace in mapped set", g_set, 3);
        chk(g_cnt == NS * NW, "R12 all ways powered", g_cnt, NS * NW);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule